// File: doc/BRIEF.md
# LCD Display Timing Controller

This block produces the scan timing for a parallel RGB LCD panel. Software programs it through a small word-wide register port. It sets the sync pulse widths, the front and back porches and the active area for both axes, the polarity of each sync pulse, and the pixel format code that the output pins use. Timing advances only on cycles where the pixel-clock enable input is high. On those cycles the block drives horizontal sync, vertical sync, data-enable and the pixel column and row of the current active pixel.

Bring-up follows three ordered stages: pixel clock, then sync generation, then display. Software sets each stage through a set-only enable register and watches the matching status bit before it requests the next stage. Shut-down runs the same stages in reverse through a set-only disable register. The sync and display stages change state only at a frame boundary, so a partial frame never reaches the panel. A start-of-frame flag drives an interrupt output. Software sets and clears the interrupt mask through two separate write-one registers.

Top module: `lcd_timing_ctrl`

## Requirements
- R1: Word addresses are: 0 sync widths, 1 vertical porches, 2 horizontal porches, 3 active size, 4 output config, 5 stage enable, 6 stage disable, 7 status, 8 interrupt enable, 9 interrupt disable, 10 interrupt mask. In registers 0 to 3, bits [CW-1:0] and [16+CW-1:16] are stored, and they read back with all other bits zero. All registers read zero after reset.
- R2: A line lasts (hsync field + 1) + (hbp field + 1) + (width field + 1) + (hfp field + 1) ticks. Horizontal sync is active for the first hsync field + 1 ticks of each line. Register 0 holds hsync-1 in the low half and vsync-1 in the high half. Register 2 holds hfp-1 in the low half and hbp-1 in the high half.
- R3: A frame lasts (vsync field + 1) + vbp field + (height field + 1) + (vfp field + 1) lines. The vertical back porch (register 1, high half) is used without adding one. Register 1 holds vfp-1 in the low half. Vertical sync is active for the first vsync field + 1 lines.
- R4: Data-enable is high only while the display stage is on and the position lies inside the active window. The window starts after sync plus back porch on each axis and is sized by register 3 (width-1 low half, height-1 high half). pix_x and pix_y count from 0 at the window's first pixel and are 0 whenever data-enable is low.
- R5: In register 4, bit 0 set makes hsync active low and bit 1 set makes vsync active low. While the sync stage is off, both pins rest at their inactive level.
- R6: Register 4 bits [9:8] drive out_mode (0 RGB444, 1 RGB565, 2 RGB666, 3 RGB888).
- R7: A write of 1 to bit 0 (pixel clock), bit 1 (sync) or bit 2 (display) of the enable register requests that stage. The pixel-clock status sets within two clocks. The sync status sets at a frame boundary only once pixel clock is on, and the display status sets at a frame boundary only once sync is on. Status bits sit at bits [2:0] of the status register.
- R8: A write of 1 to the same bits of the disable register drops the request. The display clears at a frame boundary. Sync clears at a frame boundary only once display is off. Pixel clock clears only once sync is off.
- R9: While pix_ce is low, the scan position, the sync pins and data-enable hold.
- R10: The start-of-frame flag (status bit 8) sets on the first tick of the first vertical sync line while sync is on. A read of the status register clears it.
- R11: irq is high only when the flag and the mask are both set. Bit 0 written as 1 to the interrupt-enable register sets the mask, and the same write to the interrupt-disable register clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_ce | input | 1 | Pixel-clock enable; one scan tick per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the start-of-frame flag on the status address) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| hsync | output | 1 | Horizontal sync, polarity per config |
| vsync | output | 1 | Vertical sync, polarity per config |
| de | output | 1 | Data-enable |
| pix_x | output | CW | Active column |
| pix_y | output | CW | Active row |
| out_mode | output | 2 | Pixel format code |
| irq | output | 1 | Masked start-of-frame interrupt |

## Verification
On every cycle the assertions check several properties: the stage order on the way up and the way down, data-enable only while display is on, the freeze of the counters on idle pix_ce cycles, the start-of-frame flag rising only from the scan origin, and the interrupt staying low with the mask clear. Some behaviour only the bench's scenarios can show. This covers the actual line and frame lengths, the porch decoding with the unreduced vertical back porch, the position of the first and last active pixel, polarity inversion, register readback, and the read-to-clear of the flag.

// File: rtl/lcd_tc_pkg.sv
// Package: register addresses and stage indices shared by the timing controller.
package lcd_tc_pkg;
    localparam logic [3:0] A_SYNCW  = 4'd0;
    localparam logic [3:0] A_VPORCH = 4'd1;
    localparam logic [3:0] A_HPORCH = 4'd2;
    localparam logic [3:0] A_ACTIVE = 4'd3;
    localparam logic [3:0] A_OUTCFG = 4'd4;
    localparam logic [3:0] A_STGEN  = 4'd5;
    localparam logic [3:0] A_STGDIS = 4'd6;
    localparam logic [3:0] A_STATUS = 4'd7;
    localparam logic [3:0] A_IRQEN  = 4'd8;
    localparam logic [3:0] A_IRQDIS = 4'd9;
    localparam logic [3:0] A_IRQMSK = 4'd10;

    localparam int STG_PCLK = 0;
    localparam int STG_SYNC = 1;
    localparam int STG_DISP = 2;
    localparam int NSTG     = 3;
endpackage

// File: rtl/lcd_tc_regs.sv
// Register file: holds timing, polarity and format fields, decodes the
// set-only stage strobes, and keeps the start-of-frame flag and mask.
// Assumes CW < 16 so each field fits in a 16-bit half word.
module lcd_tc_regs
    import lcd_tc_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic            rd,
    input  logic [3:0]      addr,
    input  logic [31:0]     wdata,
    input  logic            sof_evt,
    input  logic [NSTG-1:0] stage_st,
    output logic [31:0]     rdata,
    output logic [CW-1:0]   hsw_f,
    output logic [CW-1:0]   vsw_f,
    output logic [CW-1:0]   hbp_f,
    output logic [CW-1:0]   vbp_f,
    output logic [CW-1:0]   hfp_f,
    output logic [CW-1:0]   vfp_f,
    output logic [CW-1:0]   wid_f,
    output logic [CW-1:0]   hgt_f,
    output logic            hpol,
    output logic            vpol,
    output logic [1:0]      mode,
    output logic [NSTG-1:0] en_set,
    output logic [NSTG-1:0] dis_set,
    output logic            sof_flag,
    output logic            irq_mask
);
    localparam int PADW = 16 - CW;

    logic unused_wbits;
    assign unused_wbits = ^{wdata[15:CW], wdata[31:16+CW]};

    // Configuration storage, written per address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsw_f <= '0; vsw_f <= '0; hbp_f <= '0; vbp_f <= '0;
            hfp_f <= '0; vfp_f <= '0; wid_f <= '0; hgt_f <= '0;
            hpol  <= 1'b0; vpol <= 1'b0; mode <= 2'd0;
        end else if (wr) begin
            case (addr)
                A_SYNCW:  begin hsw_f <= wdata[CW-1:0]; vsw_f <= wdata[16+CW-1:16]; end
                A_VPORCH: begin vfp_f <= wdata[CW-1:0]; vbp_f <= wdata[16+CW-1:16]; end
                A_HPORCH: begin hfp_f <= wdata[CW-1:0]; hbp_f <= wdata[16+CW-1:16]; end
                A_ACTIVE: begin wid_f <= wdata[CW-1:0]; hgt_f <= wdata[16+CW-1:16]; end
                A_OUTCFG: begin hpol <= wdata[0]; vpol <= wdata[1]; mode <= wdata[9:8]; end
                default: ;
            endcase
        end
    end

    // Single-cycle stage request strobes.
    assign en_set  = (wr && addr == A_STGEN)  ? wdata[NSTG-1:0] : '0;
    assign dis_set = (wr && addr == A_STGDIS) ? wdata[NSTG-1:0] : '0;

    // Start-of-frame flag: a new event wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)                         sof_flag <= 1'b0;
        else if (sof_evt)                   sof_flag <= 1'b1;
        else if (rd && addr == A_STATUS)    sof_flag <= 1'b0;
    end

    // Interrupt mask via separate write-one set and clear addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  irq_mask <= 1'b0;
        else if (wr && addr == A_IRQEN  && wdata[0]) irq_mask <= 1'b1;
        else if (wr && addr == A_IRQDIS && wdata[0]) irq_mask <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_SYNCW:  rdata = {{PADW{1'b0}}, vsw_f, {PADW{1'b0}}, hsw_f};
            A_VPORCH: rdata = {{PADW{1'b0}}, vbp_f, {PADW{1'b0}}, vfp_f};
            A_HPORCH: rdata = {{PADW{1'b0}}, hbp_f, {PADW{1'b0}}, hfp_f};
            A_ACTIVE: rdata = {{PADW{1'b0}}, hgt_f, {PADW{1'b0}}, wid_f};
            A_OUTCFG: rdata = {22'd0, mode, 6'd0, vpol, hpol};
            A_STATUS: rdata = {23'd0, sof_flag, {(8-NSTG){1'b0}}, stage_st};
            A_IRQMSK: rdata = {31'd0, irq_mask};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/lcd_tc_stager.sv
// Stage sequencer: tracks the requested stages and moves the pixel-clock,
// sync and display status in order. Sync and display move only at a frame
// boundary. Assumes frame_end can only pulse while pixel clock is on.
module lcd_tc_stager
    import lcd_tc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSTG-1:0] en_set,
    input  logic [NSTG-1:0] dis_set,
    input  logic            frame_end,
    output logic [NSTG-1:0] st
);
    logic [NSTG-1:0] want;

    // Requested-stage register: set by enable, cleared by disable.
    always_ff @(posedge clk) begin
        if (!rst_n) want <= '0;
        else        want <= (want | en_set) & ~dis_set;
    end

    // Pixel clock: follows the request, but stays on until sync is off.
    always_ff @(posedge clk) begin
        if (!rst_n)                  st[STG_PCLK] <= 1'b0;
        else if (want[STG_PCLK])     st[STG_PCLK] <= 1'b1;
        else if (!st[STG_SYNC])      st[STG_PCLK] <= 1'b0;
    end

    // Sync: changes at a frame boundary, gated by its neighbours.
    always_ff @(posedge clk) begin
        if (!rst_n) st[STG_SYNC] <= 1'b0;
        else if (frame_end) begin
            if (want[STG_SYNC] && st[STG_PCLK])        st[STG_SYNC] <= 1'b1;
            else if (!want[STG_SYNC] && !st[STG_DISP]) st[STG_SYNC] <= 1'b0;
        end
    end

    // Display: changes at a frame boundary, needs sync on to start.
    always_ff @(posedge clk) begin
        if (!rst_n) st[STG_DISP] <= 1'b0;
        else if (frame_end) begin
            if (want[STG_DISP] && st[STG_SYNC]) st[STG_DISP] <= 1'b1;
            else if (!want[STG_DISP])           st[STG_DISP] <= 1'b0;
        end
    end
endmodule

// File: rtl/lcd_tc_scan.sv
// Scan counters: horizontal and vertical position advanced per pixel tick,
// with sync, active-window and frame-end decode. Fields are stored minus one
// except the vertical back porch. Counters sit at zero while run is low.
module lcd_tc_scan #(
    parameter int CW = 12,
    localparam int TW = CW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          pix_ce,
    input  logic [CW-1:0] hsw_f,
    input  logic [CW-1:0] vsw_f,
    input  logic [CW-1:0] hbp_f,
    input  logic [CW-1:0] vbp_f,
    input  logic [CW-1:0] hfp_f,
    input  logic [CW-1:0] vfp_f,
    input  logic [CW-1:0] wid_f,
    input  logic [CW-1:0] hgt_f,
    output logic [TW-1:0] h_cnt,
    output logic [TW-1:0] v_cnt,
    output logic          frame_end,
    output logic          in_hs,
    output logic          in_vs,
    output logic          in_act,
    output logic [CW-1:0] px,
    output logic [CW-1:0] py
);
    logic [TW-1:0] hsw_n, vsw_n, hx0, vy0, h_tot, v_tot, wid_n, hgt_n;
    logic          h_last, v_last;

    // Decoded spans in ticks and lines.
    always_comb begin
        hsw_n = TW'(hsw_f) + TW'(1);
        vsw_n = TW'(vsw_f) + TW'(1);
        wid_n = TW'(wid_f) + TW'(1);
        hgt_n = TW'(hgt_f) + TW'(1);
        hx0   = hsw_n + TW'(hbp_f) + TW'(1);
        vy0   = vsw_n + TW'(vbp_f);
        h_tot = hx0 + wid_n + TW'(hfp_f) + TW'(1);
        v_tot = vy0 + hgt_n + TW'(vfp_f) + TW'(1);
    end

    assign h_last    = (h_cnt >= h_tot - TW'(1));
    assign v_last    = (v_cnt >= v_tot - TW'(1));
    assign frame_end = run && pix_ce && h_last && v_last;

    // Position counters, advanced once per pixel tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (pix_ce) begin
            if (h_last) begin
                h_cnt <= '0;
                v_cnt <= v_last ? '0 : v_cnt + TW'(1);
            end else begin
                h_cnt <= h_cnt + TW'(1);
            end
        end
    end

    // Region decode relative to the sync pulse start.
    assign in_hs  = (h_cnt < hsw_n);
    assign in_vs  = (v_cnt < vsw_n);
    assign in_act = (h_cnt >= hx0) && (h_cnt < hx0 + wid_n) &&
                    (v_cnt >= vy0) && (v_cnt < vy0 + hgt_n);
    assign px     = CW'(h_cnt - hx0);
    assign py     = CW'(v_cnt - vy0);
endmodule

// File: rtl/lcd_timing_ctrl.sv
// Top: register-programmed LCD timing controller with staged bring-up.
// Outputs are decoded from registered state; all timing runs on pix_ce.
module lcd_timing_ctrl
    import lcd_tc_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_ce,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] pix_y,
    output logic [1:0]    out_mode,
    output logic          irq
);
    localparam int TW = CW + 2;

    logic [CW-1:0]   hsw_f, vsw_f, hbp_f, vbp_f, hfp_f, vfp_f, wid_f, hgt_f;
    logic            hpol, vpol, sof_flag, irq_mask, sof_evt, frame_end;
    logic            in_hs, in_vs, in_act;
    logic [NSTG-1:0] en_set, dis_set, stage_st;
    logic [TW-1:0]   h_cnt, v_cnt;
    logic [CW-1:0]   px, py;

    lcd_tc_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .sof_evt(sof_evt), .stage_st(stage_st),
        .rdata(reg_rdata), .hsw_f(hsw_f), .vsw_f(vsw_f), .hbp_f(hbp_f),
        .vbp_f(vbp_f), .hfp_f(hfp_f), .vfp_f(vfp_f), .wid_f(wid_f),
        .hgt_f(hgt_f), .hpol(hpol), .vpol(vpol), .mode(out_mode),
        .en_set(en_set), .dis_set(dis_set), .sof_flag(sof_flag),
        .irq_mask(irq_mask)
    );

    lcd_tc_stager u_stager (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .dis_set(dis_set),
        .frame_end(frame_end), .st(stage_st)
    );

    lcd_tc_scan #(.CW(CW)) u_scan (
        .clk(clk), .rst_n(rst_n), .run(stage_st[STG_PCLK]), .pix_ce(pix_ce),
        .hsw_f(hsw_f), .vsw_f(vsw_f), .hbp_f(hbp_f), .vbp_f(vbp_f),
        .hfp_f(hfp_f), .vfp_f(vfp_f), .wid_f(wid_f), .hgt_f(hgt_f),
        .h_cnt(h_cnt), .v_cnt(v_cnt), .frame_end(frame_end),
        .in_hs(in_hs), .in_vs(in_vs), .in_act(in_act), .px(px), .py(py)
    );

    // Start-of-frame: first tick at the scan origin with sync running.
    assign sof_evt = stage_st[STG_SYNC] && pix_ce && h_cnt == '0 && v_cnt == '0;

    // Pin drive: syncs idle at inactive level, pixel position zero off-window.
    assign hsync = (stage_st[STG_SYNC] & in_hs) ^ hpol;
    assign vsync = (stage_st[STG_SYNC] & in_vs) ^ vpol;
    assign de    = stage_st[STG_DISP] & in_act;
    assign pix_x = de ? px : '0;
    assign pix_y = de ? py : '0;
    assign irq   = sof_flag & irq_mask;
endmodule

// File: rtl/lcd_timing_ctrl_chk.sv
// Checker: cycle-level properties of the timing controller, bound to the top.
module lcd_timing_ctrl_chk #(
    parameter int TW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_ce,
    input logic          de,
    input logic          irq,
    input logic [2:0]    stage_st,
    input logic          irq_mask,
    input logic          sof_flag,
    input logic [TW-1:0] h_cnt,
    input logic [TW-1:0] v_cnt
);
    // R7
    sync_after_pclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_st[1]) |-> $past(stage_st[0]));
    // R7
    disp_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_st[2]) |-> $past(stage_st[1]));
    // R8
    pclk_off_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stage_st[0]) |-> (!stage_st[1] && !$past(stage_st[1])));
    // R8
    sync_off_after_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stage_st[1]) |-> !$past(stage_st[2]));
    // R4
    de_needs_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> stage_st[2]);
    // R9
    idle_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_ce && stage_st[0]) |=> ($stable(h_cnt) && $stable(v_cnt)));
    // R10
    sof_at_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sof_flag) |-> ($past(h_cnt) == '0 && $past(v_cnt) == '0));
    // R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_mask |-> !irq);
endmodule

bind lcd_timing_ctrl lcd_timing_ctrl_chk #(.TW(CW + 2)) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .de(de), .irq(irq),
    .stage_st(stage_st), .irq_mask(irq_mask), .sof_flag(sof_flag),
    .h_cnt(h_cnt), .v_cnt(v_cnt)
);

// File: tb/lcd_timing_ctrl_tb.sv
// Directed bench for the timing controller.
// Timing: hsync 2, hbp 3, width 8, hfp 2 (line 15); vsync 1, vbp 2, height 4, vfp 1 (frame 8 lines, 120 ticks).
module lcd_timing_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_ce = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hsync, vsync, de, irq;
    logic [11:0] pix_x, pix_y;
    logic [1:0]  out_mode;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lcd_timing_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_x(pix_x), .pix_y(pix_y), .out_mode(out_mode), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #2 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic wait_status(input int bitn, input logic val, output bit ok);
        logic [31:0] d;
        ok = 0;
        for (int i = 0; i < 1000; i++) begin
            rd_reg(4'd7, d);
            if (d[bitn] == val) begin ok = 1; break; end
        end
    endtask

    // Samples one frame starting at a vsync activation.
    task automatic measure(input logic hp, input logic vp, output int de_n, output int hs_n,
                           output int vs_n, output int first_de, output int len,
                           output int fx, output int fy, output int lx, output int ly,
                           output int bad);
        logic prev, cur;
        de_n = 0; hs_n = 0; vs_n = 0; first_de = -1; len = -1;
        fx = -1; fy = -1; lx = -1; ly = -1; bad = 0;
        prev = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            cur = vsync ^ vp;
            if (cur && !prev) break;
            prev = cur;
        end
        for (int idx = 0; idx < 400; idx++) begin
            if (idx > 0) begin
                @(negedge clk);
                cur = vsync ^ vp;
                if (cur && !prev) begin len = idx; break; end
                prev = cur;
            end else prev = 1'b1;
            if (hsync ^ hp) hs_n++;
            if (vsync ^ vp) vs_n++;
            if (de) begin
                de_n++;
                if (first_de < 0) begin first_de = idx; fx = pix_x; fy = pix_y; end
                lx = pix_x; ly = pix_y;
            end else if (pix_x != 0 || pix_y != 0) bad++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 11; a++) begin
            rd_reg(4'(a), d);
            check(d == 0, "R1 reset readback", d, 0);
        end
        check(hsync == 0 && vsync == 0 && de == 0 && irq == 0, "R5 idle pins after reset",
              {hsync, vsync, de, irq}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr_reg(4'd0, 32'h0000_0001);
        wr_reg(4'd1, 32'h0002_0000);
        wr_reg(4'd2, 32'h0002_0001);
        wr_reg(4'd3, 32'h0003_0007);
        wr_reg(4'd4, 32'h0000_0200);
        rd_reg(4'd2, d); check(d == 32'h0002_0001, "R1 hporch readback", d, 32'h0002_0001);
        rd_reg(4'd3, d); check(d == 32'h0003_0007, "R1 active readback", d, 32'h0003_0007);
        wr_reg(4'd1, 32'hFFFF_FFFF);
        rd_reg(4'd1, d); check(d == 32'h0FFF_0FFF, "R1 unused bits read zero", d, 32'h0FFF_0FFF);
        wr_reg(4'd1, 32'h0002_0000);
        check(out_mode == 2'd2, "R6 out_mode", out_mode, 2);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        bit ok;
        wr_reg(4'd5, 32'h4);
        repeat (50) @(negedge clk);
        rd_reg(4'd7, d);
        check(d[2:0] == 0, "R7 display ignored before sync", d[2:0], 0);
        wr_reg(4'd5, 32'h1);
        repeat (2) @(negedge clk);
        rd_reg(4'd7, d);
        check(d[2:0] == 3'b001, "R7 pixel clock up", d[2:0], 1);
        wr_reg(4'd5, 32'h2);
        wait_status(1, 1'b1, ok);
        check(ok && hsync && vsync, "R7 sync up at frame boundary", {ok, hsync, vsync}, 3'b111);
        wait_status(2, 1'b1, ok);
        check(ok && vsync && !de, "R7 display up at frame boundary", {ok, vsync, de}, 3'b110);
    endtask

    task automatic t_frame(input logic hp, input logic vp, input string tag);
        int de_n, hs_n, vs_n, fde, len, fx, fy, lx, ly, bad;
        measure(hp, vp, de_n, hs_n, vs_n, fde, len, fx, fy, lx, ly, bad);
        check(len == 120, {tag, " R3 frame length"}, len, 120);
        check(hs_n == 16, {tag, " R2 hsync active ticks"}, hs_n, 16);
        check(vs_n == 15, {tag, " R3 vsync active ticks"}, vs_n, 15);
        check(de_n == 32, {tag, " R4 de count"}, de_n, 32);
        check(fde == 50, {tag, " R4 first de offset"}, fde, 50);
        check(fx == 0 && fy == 0, {tag, " R4 first pixel"}, {fx[15:0], fy[15:0]}, 0);
        check(lx == 7 && ly == 3, {tag, " R4 last pixel"}, {lx[15:0], ly[15:0]}, 32'h0007_0003);
        check(bad == 0, {tag, " R4 position zero outside window"}, bad, 0);
    endtask

    task automatic t_pol();
        wr_reg(4'd4, 32'h0000_0203);
        t_frame(1'b1, 1'b1, "R5 inverted");
        check(out_mode == 2'd2, "R6 out_mode kept", out_mode, 2);
    endtask

    task automatic t_freeze();
        logic [11:0] x0;
        logic h0, v0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (de && pix_x == 3) break;
        end
        pix_ce = 1'b0;
        x0 = pix_x; h0 = hsync; v0 = vsync;
        repeat (10) @(negedge clk);
        check(de && pix_x == x0 && hsync == h0 && vsync == v0, "R9 hold on idle pix_ce",
              {de, pix_x}, {1'b1, x0});
        pix_ce = 1'b1;
        @(negedge clk);
        check(pix_x == x0 + 1, "R9 resume", pix_x, x0 + 1);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        rd_reg(4'd7, d);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!vsync) break;
        end
        repeat (2) @(negedge clk);
        rd_reg(4'd7, d);
        check(d[8] == 1 && irq == 0, "R10/R11 flag set, irq masked", {d[8], irq}, 2'b10);
        rd_reg(4'd7, d);
        check(d[8] == 0, "R10 flag cleared by read", d[8], 0);
        wr_reg(4'd8, 32'h1);
        rd_reg(4'd10, d);
        check(d == 1, "R11 mask set", d, 1);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (irq) break;
        end
        check(irq == 1, "R11 irq asserts", irq, 1);
        rd_reg(4'd7, d);
        @(negedge clk);
        check(irq == 0, "R10 read clears irq", irq, 0);
        wr_reg(4'd9, 32'h1);
        repeat (200) @(negedge clk);
        check(irq == 0, "R11 mask cleared", irq, 0);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        bit ok;
        wr_reg(4'd6, 32'h1);
        repeat (300) @(negedge clk);
        rd_reg(4'd7, d);
        check(d[2:0] == 3'b111, "R8 pixel clock held while sync on", d[2:0], 7);
        wr_reg(4'd6, 32'h2);
        repeat (300) @(negedge clk);
        rd_reg(4'd7, d);
        check(d[2:0] == 3'b111, "R8 sync held while display on", d[2:0], 7);
        wr_reg(4'd6, 32'h4);
        wait_status(2, 1'b0, ok);
        check(ok && !vsync, "R8 display off at frame boundary (vsync active low)", {ok, vsync}, 2'b10);
        wait_status(1, 1'b0, ok);
        check(ok && hsync && vsync, "R8 sync off, pins inactive", {ok, hsync, vsync}, 3'b111);
        repeat (2) @(negedge clk);
        rd_reg(4'd7, d);
        check(d[2:0] == 0 && !de, "R8 pixel clock off last", {de, d[2:0]}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_enable();
        t_frame(1'b0, 1'b0, "R2 normal");
        t_pol();
        t_freeze();
        t_irq();
        t_disable();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule